// File: doc/BRIEF.md
# Power-Down Mode Controller

This block watches a byte-wide instruction stream for three power-saving opcodes and drives the clock and port controls of a small microcontroller from them. One opcode gates the CPU clock while the crystal oscillator keeps running, so execution can restart on the next edge. A second opcode also stops the oscillator, so leaving it needs a settling delay. Reset skips that delay. A third opcode puts the I/O ports into high impedance. Which ports float depends on whether the program runs from on-chip or off-chip memory.

The core presents an opcode with a one-cycle strobe. A wake pulse, which an interrupt would raise, ends either halt depth. Every output is a register and changes on the clock edge after the input that causes it. The float masks use 1 to mean high impedance for each bit. The settling delay is a parameter, `WAIT_CYCLES`, with a default of 1024.

Top module: `pdm_ctrl`

## Requirements
- R1: On the edge after reset is asserted, `cpu_clk_en_o`, `osc_en_o` and `resume_rdy_o` are 1, and all three float masks are 8'h00.
- R2: A strobe of opcode 8'h01 while running takes effect on the next edge. `cpu_clk_en_o` goes to 0, while `osc_en_o` and `resume_rdy_o` stay 1.
- R3: In the clock-gated state, a wake pulse sets `cpu_clk_en_o` to 1 on the next edge, with no settling delay.
- R4: A strobe of opcode 8'h82 while running takes effect on the next edge. `cpu_clk_en_o`, `osc_en_o` and `resume_rdy_o` all go to 0 and stay there until a wake or a reset.
- R5: A wake in the oscillator-stopped state sets `osc_en_o` on the next edge. After that, `cpu_clk_en_o` stays 0 for exactly `WAIT_CYCLES` cycles, then rises together with `resume_rdy_o`.
- R6: Reset in either halt state, including during the settling delay, restores all three enables on the next edge with no delay, and clears every float mask.
- R7: A strobe of opcode 8'hA2 while running with `ext_rom_i`=0 sets all three masks to 8'hFF from the next edge on.
- R8: With the float state set and `ext_rom_i`=1, the masks are: port 1 8'hFF, port 2 8'hF0 (bits 3..0 keep driving), bus port 8'h00. The masks follow a change of `ext_rom_i` one edge later.
- R9: Once set, the float state survives both halt states and their wakes. Only reset clears it.
- R10: The block ignores:
  - strobes while not running;
  - strobes of any other opcode;
  - a wake while running or during the settling delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also a wake source that skips the delay |
| op_i | input | 8 | Instruction byte |
| op_valid_i | input | 1 | One-cycle strobe qualifying `op_i` |
| wake_i | input | 1 | Wake request pulse |
| ext_rom_i | input | 1 | 1 = program fetched off-chip, 0 = on-chip |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| resume_rdy_o | output | 1 | Oscillator considered stable |
| p1_hiz_o | output | 8 | Port 1 float mask, 1 = high impedance |
| p2_hiz_o | output | 8 | Port 2 float mask, 1 = high impedance |
| bus_hiz_o | output | 8 | Bus port float mask, 1 = high impedance |

## Verification
The hardest situation to reach is a reset that lands partway through the settling delay. It needs an 8'h82 strobe, then a wake, then a reset timed several cycles into the count. A directed sequence builds exactly that chain, and a second directed sequence applies reset in the stopped state. Around these, random phases mix strobes of the three opcodes with other bytes, random wakes and random changes of the memory-mode input. This drives the float state through both halt depths in both modes, and a bench model checks every cycle against the requirements.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STOP = 2'd2,
    ST_WAIT = 2'd3
  } pdm_state_t;

  localparam logic [7:0] OP_HALT = 8'h01;
  localparam logic [7:0] OP_HLTS = 8'h82;
  localparam logic [7:0] OP_FLT  = 8'hA2;
endpackage

// File: rtl/pdm_decode.sv
module pdm_decode (
  input  logic [7:0] op_i,
  input  logic       strobe_i,
  input  logic       run_i,
  output logic       halt_o,
  output logic       stop_o,
  output logic       float_o
);
  import pdm_pkg::*;

  logic take;

  always_comb begin
    take    = strobe_i && run_i;
    halt_o  = take && (op_i == OP_HALT);
    stop_o  = take && (op_i == OP_HLTS);
    float_o = take && (op_i == OP_FLT);
  end
endmodule

// File: rtl/pdm_settle_timer.sv
module pdm_settle_timer #(
  parameter int WAIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt <= '0;
    end else if (run_i && (cnt != LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done_o = run_i && (cnt == LAST);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt <= LAST));
endmodule

// File: rtl/pdm_float_mask.sv
module pdm_float_mask #(
  parameter int PORT_W  = 8,
  parameter int P2_KEEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              ext_i,
  output logic [PORT_W-1:0] p1_o,
  output logic [PORT_W-1:0] p2_o,
  output logic [PORT_W-1:0] bus_o
);
  logic              float_q;
  logic              float_nx;
  logic [PORT_W-1:0] p2_nx;

  assign float_nx = float_q || set_i;

  for (genvar b = 0; b < PORT_W; b++) begin : g_p2
    if (b < P2_KEEP) begin : g_low
      assign p2_nx[b] = float_nx && !ext_i;
    end else begin : g_high
      assign p2_nx[b] = float_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      float_q <= 1'b0;
      p1_o    <= '0;
      p2_o    <= '0;
      bus_o   <= '0;
    end else begin
      float_q <= float_nx;
      p1_o    <= {PORT_W{float_nx}};
      p2_o    <= p2_nx;
      bus_o   <= {PORT_W{float_nx && !ext_i}};
    end
  end

  p_float_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    float_q |=> (p1_o == {PORT_W{1'b1}}));
  p_bus_kept_ext_r8: assert property (@(posedge clk) disable iff (rst)
    ext_i |=> (bus_o == '0));
  p_set_floats_r7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (p1_o == {PORT_W{1'b1}}));
endmodule

// File: rtl/pdm_ctrl.sv
module pdm_ctrl #(
  parameter int WAIT_CYCLES = 1024,
  parameter int PORT_W      = 8,
  parameter int P2_KEEP     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        op_i,
  input  logic              op_valid_i,
  input  logic              wake_i,
  input  logic              ext_rom_i,
  output logic              cpu_clk_en_o,
  output logic              osc_en_o,
  output logic              resume_rdy_o,
  output logic [PORT_W-1:0] p1_hiz_o,
  output logic [PORT_W-1:0] p2_hiz_o,
  output logic [PORT_W-1:0] bus_hiz_o
);
  import pdm_pkg::*;

  pdm_state_t st, st_nx;
  logic halt_hit, stop_hit, float_hit;
  logic wait_start, wait_done;

  pdm_decode u_dec (
    .op_i     (op_i),
    .strobe_i (op_valid_i),
    .run_i    (st == ST_RUN),
    .halt_o   (halt_hit),
    .stop_o   (stop_hit),
    .float_o  (float_hit)
  );

  assign wait_start = (st == ST_STOP) && wake_i;

  pdm_settle_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start_i (wait_start),
    .run_i   (st == ST_WAIT),
    .done_o  (wait_done)
  );

  pdm_float_mask #(.PORT_W(PORT_W), .P2_KEEP(P2_KEEP)) u_flt (
    .clk   (clk),
    .rst   (rst),
    .set_i (float_hit),
    .ext_i (ext_rom_i),
    .p1_o  (p1_hiz_o),
    .p2_o  (p2_hiz_o),
    .bus_o (bus_hiz_o)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_RUN: begin
        if (halt_hit)      st_nx = ST_HALT;
        else if (stop_hit) st_nx = ST_STOP;
      end
      ST_HALT: if (wake_i)    st_nx = ST_RUN;
      ST_STOP: if (wake_i)    st_nx = ST_WAIT;
      ST_WAIT: if (wait_done) st_nx = ST_RUN;
      default: st_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RUN;
      cpu_clk_en_o <= 1'b1;
      osc_en_o     <= 1'b1;
      resume_rdy_o <= 1'b1;
    end else begin
      st           <= st_nx;
      cpu_clk_en_o <= (st_nx == ST_RUN);
      osc_en_o     <= (st_nx != ST_STOP);
      resume_rdy_o <= (st_nx == ST_RUN) || (st_nx == ST_HALT);
    end
  end

  p_halt_keeps_osc_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && halt_hit) |=> (!cpu_clk_en_o && osc_en_o && resume_rdy_o));
  p_halt_wake_fast_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT && wake_i) |=> cpu_clk_en_o);
  p_hlts_stops_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && stop_hit) |=> (!osc_en_o && !cpu_clk_en_o && !resume_rdy_o));
  p_reset_bypass_r6: assert property (@(posedge clk)
    rst |=> (cpu_clk_en_o && osc_en_o && resume_rdy_o && p1_hiz_o == '0));
  p_halt_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HALT && !wake_i) |=> !cpu_clk_en_o);
  p_wait_osc_on_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> osc_en_o);
endmodule

// File: tb/pdm_ctrl_tb.sv
module pdm_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op = 8'h00;
  logic       opv = 1'b0;
  logic       wake = 1'b0;
  logic       ext = 1'b0;
  logic       cpu, osc, rdy;
  logic [7:0] p1, p2, bus;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_st = 0;
  int m_cnt = 0;
  bit m_flt = 0;
  bit m_ext = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_ctrl #(.WAIT_CYCLES(W)) u_dut (
    .clk(clk), .rst(rst), .op_i(op), .op_valid_i(opv), .wake_i(wake),
    .ext_rom_i(ext), .cpu_clk_en_o(cpu), .osc_en_o(osc), .resume_rdy_o(rdy),
    .p1_hiz_o(p1), .p2_hiz_o(p2), .bus_hiz_o(bus)
  );

  function automatic logic [7:0] exp_p2(bit f, bit e);
    return f ? (e ? 8'hF0 : 8'hFF) : 8'h00;
  endfunction
  function automatic logic [7:0] exp_bus(bit f, bit e);
    return (f && !e) ? 8'hFF : 8'h00;
  endfunction

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_st = 0; m_cnt = 0; m_flt = 0;
    end else begin
      case (m_st)
        0: if (opv && op == 8'h01) m_st = 1;
           else if (opv && op == 8'h82) m_st = 2;
           else if (opv && op == 8'hA2) m_flt = 1;
        1: if (wake) m_st = 0;
        2: if (wake) begin m_st = 3; m_cnt = 0; end
        default: if (m_cnt == W-1) m_st = 0; else m_cnt++;
      endcase
    end
    m_ext = ext;
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, "cpu", {7'b0, cpu}, {7'b0, m_st == 0});
    chk(tag, "osc", {7'b0, osc}, {7'b0, m_st != 2});
    chk(tag, "rdy", {7'b0, rdy}, {7'b0, m_st < 2});
    chk(tag, "p1", p1, m_flt ? 8'hFF : 8'h00);
    chk(tag, "p2", p2, exp_p2(m_flt, m_ext));
    chk(tag, "bus", bus, exp_bus(m_flt, m_ext));
    opv = 0; wake = 0; rst = 0;
  endtask

  task automatic strobe(logic [7:0] o, string tag);
    op = o; opv = 1; cycle(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1; cycle("R1");
    // R2 / R3: clock gate with instant restart
    strobe(8'h01, "R2");
    cycle("R2"); cycle("R10");
    op = 8'h82; opv = 1; cycle("R10");      // strobe ignored while gated
    wake = 1; cycle("R3");
    cycle("R3");
    // R4 / R5: oscillator stop and settling count
    strobe(8'h82, "R4");
    repeat (5) cycle("R4");
    wake = 1; cycle("R5");
    n = 0;
    while (!cpu && n < 10*W) begin
      if (osc) n++;
      wake = 1;                            // wake during delay ignored (R10)
      cycle("R5");
    end
    chk("R5", "wait_len", n[7:0], 8'(W));
    // R6: reset inside the settling delay
    strobe(8'hA2, "R7");
    strobe(8'h82, "R6");
    wake = 1; cycle("R6");
    repeat (7) cycle("R6");
    rst = 1; cycle("R6");
    chk("R6", "bypass", {7'b0, cpu}, 8'h01);
    // R6: reset in stopped state
    strobe(8'h82, "R6");
    rst = 1; cycle("R6");
    // R7 / R8 masks in both modes
    ext = 0; strobe(8'h5A, "R10");
    strobe(8'hA2, "R7"); cycle("R7");
    ext = 1; cycle("R8"); cycle("R8");
    ext = 0; cycle("R8");
    // R9: float survives both halt depths
    ext = 1;
    strobe(8'h01, "R9"); wake = 1; cycle("R9");
    strobe(8'h82, "R9"); wake = 1; cycle("R9");
    while (!cpu) cycle("R9");
    rst = 1; cycle("R9");
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4)       begin op = 8'h01; opv = 1; end
      else if (r < 7)  begin op = 8'h82; opv = 1; end
      else if (r < 10) begin op = 8'hA2; opv = 1; end
      else if (r < 20) begin op = 8'($urandom); opv = 1; end
      if ($urandom_range(0, 9) == 0) wake = 1;
      if ($urandom_range(0, 19) == 0) ext = ~ext;
      if ($urandom_range(0, 399) == 0) rst = 1;
      cycle("R10");
    end
    finish_run();
  end
endmodule